// File: doc/BRIEF.md
# Axis Counter Capture and Clear Controller

This block sits beside two 32-bit counters of one motion axis: a commanded-pulse counter and an encoder position counter. Each counter advances by one on every cycle in which its step input is high. Two external event inputs can act on these counters. The capture input can copy counter values into a latch register per counter, and it can also zero counters. The zero input can only zero counters. Both event inputs are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and the block acts only on its rising transition.

A host programs three 2-bit selectors through a small write port. One selector picks the counters to copy on a capture event. One picks the counters to zero on a capture event. One picks the counters to zero on a zero event. The block adjusts the copy selection so that a counter is always saved before it is zeroed. A lock option copies both counters together whenever any copy is selected. Writes are refused while the axis reports itself busy. The host reads the latch registers back through a read port. Each latch register has a valid flag that sets on a copy and drops when the host reads that register.

Top module: `axis_count_capture`

## Requirements
- R1: After synchronous reset, all three selectors are 0 (no action), both counters and both latch registers are 0, both valid flags are low and `wr_err` is low.
- R2: A counter with its step input high, and no zero action in that cycle, increments by exactly one at each clock edge.
- R3: All selectors use the same encoding: 0 selects no counter, 1 the pulse counter, 2 the encoder counter, 3 both. A capture event copies each selected counter's value from before that edge into its latch register.
- R4: An event acts once per low-to-high transition of its input. The action takes effect at the third rising clock edge after the input rises. Holding the input high causes no further action.
- R5: A counter selected for zeroing on a capture event is also copied on that event, even if the copy selector leaves it out.
- R6: When `lock_both` is high and the copy selection is non-zero after the R5 adjustment, both counters are copied.
- R7: When `ltc_enable` is low, capture events cause neither copying nor zeroing.
- R8: A zero event clears the counters chosen by the zero-event selector. When `clr_support` is low, zero events have no effect.
- R9: A zero action in the same cycle as a step leaves that counter at 0. A copy in that same event saves the value from before the zero action.
- R10: `rd_data` shows the pulse latch register when `rd_sel` is 0 and the encoder latch register when `rd_sel` is 1. A valid flag sets on a copy and clears at the clock edge where `rd_en` is high with `rd_sel` pointing at that latch register.
- R11: A write with `busy` high sets `wr_err` to 1 and leaves all selectors unchanged. A write with `busy` low stores the selectors and sets `wr_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_step | input | 1 | Count enable, pulse counter |
| enc_step | input | 1 | Count enable, encoder counter |
| ltc_in | input | 1 | Asynchronous capture event input |
| clr_in | input | 1 | Asynchronous zero event input |
| ltc_enable | input | 1 | Allows capture events to be recognised |
| clr_support | input | 1 | Allows zero events to be recognised |
| lock_both | input | 1 | Any copy selection copies both counters |
| busy | input | 1 | Axis running; selector writes are refused |
| wr_en | input | 1 | Selector write strobe |
| wr_lat_sel | input | 2 | Counters copied on a capture event |
| wr_zero_ltc | input | 2 | Counters zeroed on a capture event |
| wr_zero_clr | input | 2 | Counters zeroed on a zero event |
| wr_err | output | 1 | Result of last write, 1 = refused |
| rd_en | input | 1 | Latch read strobe, clears that valid flag |
| rd_sel | input | 1 | 0 = pulse latch, 1 = encoder latch |
| rd_data | output | 32 | Selected latch register |
| pulse_valid | output | 1 | Pulse latch holds an unread copy |
| enc_valid | output | 1 | Encoder latch holds an unread copy |
| pulse_count | output | 32 | Pulse counter value |
| enc_count | output | 32 | Encoder counter value |

## Verification
The hardest case to reach from the ports is a zero action that lands in the same cycle as a step, because the action arrives three edges after the input rises. To get there, the stimulus holds the step input high across the whole synchroniser delay. The expected latch value is then two counts above the starting value and the counter ends at 0. The sweep also runs through every pair of copy and zero selectors, with and without the lock option. This covers the combinations where R5 and R6 change the copy set and the latch registers can be told apart.

// File: rtl/axcap_pkg.sv
package axcap_pkg;

    localparam int NUM_CNT = 2;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_ENC   = 2'd2,
        SEL_BOTH  = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e zero_clr;
        sel_e zero_ltc;
        sel_e lat_ltc;
    } mode_t;

    // bit 0 = pulse counter, bit 1 = encoder counter
    function automatic logic [NUM_CNT-1:0] copy_mask(mode_t m, logic lock);
        logic [NUM_CNT-1:0] r;
        r = logic'(m.lat_ltc) | logic'(m.zero_ltc);
        r = NUM_CNT'(m.lat_ltc) | NUM_CNT'(m.zero_ltc);
        if (lock && (r != '0)) begin
            r = '1;
        end
        return r;
    endfunction

    function automatic logic [NUM_CNT-1:0] sel_bits(sel_e s);
        return NUM_CNT'(s);
    endfunction

endpackage

// File: rtl/axcap_sync_edge.sv
module axcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;

    // R4: an event produces a single-cycle action pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/axcap_mode_reg.sv
module axcap_mode_reg
    import axcap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  busy,
    input  mode_t wr_mode,
    output mode_t mode_q,
    output logic  wr_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{zero_clr: SEL_NONE, zero_ltc: SEL_NONE, lat_ltc: SEL_NONE};
            wr_err <= 1'b0;
        end else if (wr_en) begin
            if (busy) begin
                wr_err <= 1'b1;
            end else begin
                mode_q <= wr_mode;
                wr_err <= 1'b0;
            end
        end
    end

    a_r1_reset_mode: assert property (@(posedge clk)
        rst |=> (mode_q == '0 && !wr_err));

    a_r11_busy_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> (wr_err && mode_q == $past(mode_q)));

endmodule

// File: rtl/axcap_count_unit.sv
module axcap_count_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         zero,
    input  logic         cap,
    input  logic         rd_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] lat,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (zero) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat   <= '0;
            valid <= 1'b0;
        end else begin
            if (cap) begin
                lat <= cnt;
            end
            if (cap) begin
                valid <= 1'b1;
            end else if (rd_clr) begin
                valid <= 1'b0;
            end
        end
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (step && !zero) |=> (cnt == $past(cnt) + W'(1)));

    a_r9_zero_wins: assert property (@(posedge clk) disable iff (rst)
        zero |=> (cnt == '0));

    a_r3_capture_old: assert property (@(posedge clk) disable iff (rst)
        cap |=> (lat == $past(cnt)));

    a_r10_valid_set: assert property (@(posedge clk) disable iff (rst)
        cap |=> valid);

endmodule

// File: rtl/axis_count_capture.sv
module axis_count_capture
    import axcap_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_step,
    input  logic             enc_step,
    input  logic             ltc_in,
    input  logic             clr_in,
    input  logic             ltc_enable,
    input  logic             clr_support,
    input  logic             lock_both,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [1:0]       wr_lat_sel,
    input  logic [1:0]       wr_zero_ltc,
    input  logic [1:0]       wr_zero_clr,
    output logic             wr_err,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             pulse_valid,
    output logic             enc_valid,
    output logic [CNT_W-1:0] pulse_count,
    output logic [CNT_W-1:0] enc_count
);
    mode_t                             wr_mode;
    mode_t                             mode_q;
    logic                              ltc_rise;
    logic                              clr_rise;
    logic                              ltc_ok;
    logic                              clr_ok;
    logic [NUM_CNT-1:0]                step_v;
    logic [NUM_CNT-1:0]                zero_v;
    logic [NUM_CNT-1:0]                cap_v;
    logic [NUM_CNT-1:0]                rdclr_v;
    logic [NUM_CNT-1:0]                valid_v;
    logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_v;
    logic [NUM_CNT-1:0][CNT_W-1:0]     lat_v;

    always_comb begin
        wr_mode.lat_ltc  = sel_e'(wr_lat_sel);
        wr_mode.zero_ltc = sel_e'(wr_zero_ltc);
        wr_mode.zero_clr = sel_e'(wr_zero_clr);
    end

    axcap_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .busy    (busy),
        .wr_mode (wr_mode),
        .mode_q  (mode_q),
        .wr_err  (wr_err)
    );

    axcap_sync_edge #(.STAGES(SYNC_STGS)) u_ltc_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (ltc_in),
        .rise (ltc_rise)
    );

    axcap_sync_edge #(.STAGES(SYNC_STGS)) u_clr_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (clr_in),
        .rise (clr_rise)
    );

    assign ltc_ok = ltc_rise & ltc_enable;
    assign clr_ok = clr_rise & clr_support;

    always_comb begin
        cap_v  = ltc_ok ? copy_mask(mode_q, lock_both) : '0;
        zero_v = (ltc_ok ? sel_bits(mode_q.zero_ltc) : '0)
               | (clr_ok ? sel_bits(mode_q.zero_clr) : '0);
    end

    assign step_v = {enc_step, pulse_step};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign rdclr_v[i] = rd_en && (rd_sel == i[0]);

        axcap_count_unit #(.W(CNT_W)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .step   (step_v[i]),
            .zero   (zero_v[i]),
            .cap    (cap_v[i]),
            .rd_clr (rdclr_v[i]),
            .cnt    (cnt_v[i]),
            .lat    (lat_v[i]),
            .valid  (valid_v[i])
        );
    end

    assign rd_data     = lat_v[rd_sel];
    assign pulse_count = cnt_v[0];
    assign enc_count   = cnt_v[1];
    assign pulse_valid = valid_v[0];
    assign enc_valid   = valid_v[1];

    // R5: zeroing a counter on a capture event always saves it first
    a_r5_zero_implies_copy: assert property (@(posedge clk) disable iff (rst)
        (zero_v[0] && ltc_ok && mode_q.zero_ltc[0]) |=> pulse_valid);

    // R7: with capture disabled, no valid flag rises without a zero event path
    a_r7_ltc_gated: assert property (@(posedge clk) disable iff (rst)
        (!ltc_enable && !pulse_valid) |=> !pulse_valid);

endmodule

// File: tb/test_axis_count_capture.sv
module test_axis_count_capture;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pulse_step = 0, enc_step = 0, ltc_in = 0, clr_in = 0;
    logic        ltc_enable = 1, clr_support = 1, lock_both = 0, busy = 0;
    logic        wr_en = 0, rd_en = 0, rd_sel = 0;
    logic [1:0]  wr_lat_sel = 0, wr_zero_ltc = 0, wr_zero_clr = 0;
    logic        wr_err, pulse_valid, enc_valid;
    logic [31:0] rd_data, pulse_count, enc_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] e_pc = 0, e_ec = 0, e_lp = 0, e_le = 0;
    logic        e_vp = 0, e_ve = 0;
    logic [1:0]  m_lat = 0, m_zl = 0, m_zc = 0;

    always #4 clk = ~clk;

    axis_count_capture i_axis_count_capture (
        .clk(clk), .rst(rst), .pulse_step(pulse_step), .enc_step(enc_step),
        .ltc_in(ltc_in), .clr_in(clr_in), .ltc_enable(ltc_enable),
        .clr_support(clr_support), .lock_both(lock_both), .busy(busy),
        .wr_en(wr_en), .wr_lat_sel(wr_lat_sel), .wr_zero_ltc(wr_zero_ltc),
        .wr_zero_clr(wr_zero_clr), .wr_err(wr_err), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .pulse_valid(pulse_valid),
        .enc_valid(enc_valid), .pulse_count(pulse_count), .enc_count(enc_count)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counts(string req);
        chk(req, pulse_count, e_pc);
        chk(req, enc_count, e_ec);
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_steps(logic p, logic e, int n);
        pulse_step = p; enc_step = e;
        repeat (n) @(posedge clk);
        @(negedge clk);
        pulse_step = 0; enc_step = 0;
        if (p) e_pc += 32'(n);
        if (e) e_ec += 32'(n);
    endtask

    task automatic write_mode(logic b, logic [1:0] l, logic [1:0] zl, logic [1:0] zc);
        busy = b; wr_en = 1; wr_lat_sel = l; wr_zero_ltc = zl; wr_zero_clr = zc;
        @(posedge clk); @(negedge clk);
        wr_en = 0; busy = 0;
        chk("R11 wr_err", 32'(wr_err), 32'(b));
        if (!b) begin m_lat = l; m_zl = zl; m_zc = zc; end
    endtask

    task automatic model_ltc();
        logic [1:0] cm;
        if (!ltc_enable) return;
        cm = m_lat | m_zl;
        if (lock_both && cm != 0) cm = 2'b11;
        if (cm[0]) begin e_lp = e_pc; e_vp = 1; end
        if (cm[1]) begin e_le = e_ec; e_ve = 1; end
        if (m_zl[0]) e_pc = 0;
        if (m_zl[1]) e_ec = 0;
    endtask

    task automatic ltc_event();
        ltc_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ltc_in = 0;
        model_ltc();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_event();
        clr_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        clr_in = 0;
        if (clr_support) begin
            if (m_zc[0]) e_pc = 0;
            if (m_zc[1]) e_ec = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_latch(string req, logic s);
        rd_sel = s; rd_en = 1;
        #1;
        chk({req, " R10 valid"}, 32'(s ? enc_valid : pulse_valid), 32'(s ? e_ve : e_vp));
        chk({req, " R10 data"}, rd_data, s ? e_le : e_lp);
        @(posedge clk); @(negedge clk);
        rd_en = 0;
        if (s) e_ve = 0; else e_vp = 0;
        chk("R10 valid cleared", 32'(s ? enc_valid : pulse_valid), 32'(0));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check_counts("R1 counters");
        chk("R1 pulse_valid", 32'(pulse_valid), 0);
        chk("R1 enc_valid", 32'(enc_valid), 0);
        chk("R1 wr_err", 32'(wr_err), 0);
        chk("R1 rd_data", rd_data, 0);
        // R1: default selectors do nothing on a capture event
        do_steps(1, 1, 4);
        ltc_event();
        check_counts("R1 no action");
        chk("R1 no valid", 32'(pulse_valid | enc_valid), 0);

        // R3 R5 R6 sweep over all selector pairs and lock option
        for (int lk = 0; lk < 2; lk++) begin
            for (int l = 0; l < 4; l++) begin
                for (int z = 0; z < 4; z++) begin
                    lock_both = lk[0];
                    write_mode(0, 2'(l), 2'(z), 2'b00);
                    do_steps(1, 0, 3 + l);
                    do_steps(0, 1, 5 + z);
                    ltc_event();
                    check_counts("R3 R5 R6 counts");
                    read_latch("R3 R5 R6 pulse", 0);
                    read_latch("R3 R5 R6 enc", 1);
                end
            end
        end
        lock_both = 0;

        // R7 capture disabled
        ltc_enable = 0;
        write_mode(0, 2'b11, 2'b11, 2'b00);
        do_steps(1, 1, 6);
        ltc_event();
        check_counts("R7 counts kept");
        chk("R7 no valid", 32'(pulse_valid | enc_valid), 0);
        ltc_enable = 1;

        // R8 zero event sweep
        for (int s = 0; s < 2; s++) begin
            for (int z = 0; z < 4; z++) begin
                clr_support = s[0];
                write_mode(0, 2'b00, 2'b00, 2'(z));
                do_steps(1, 1, 2 + z);
                clr_event();
                check_counts("R8 zero event");
                chk("R8 no copy", 32'(pulse_valid | enc_valid), 0);
            end
        end
        clr_support = 1;

        // R4 held input acts once; timing of third edge
        write_mode(0, 2'b01, 2'b01, 2'b00);
        do_steps(1, 0, 7);
        ltc_in = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 not yet", pulse_count, e_pc);
        @(posedge clk); @(negedge clk);
        model_ltc();
        chk("R4 third edge", pulse_count, 0);
        do_steps(1, 0, 4);
        chk("R4 held no repeat", pulse_count, e_pc);
        ltc_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_latch("R4 latch", 0);

        // R9 zero coincides with step: hold step across the event
        do_steps(1, 0, 9);
        pulse_step = 1; ltc_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        pulse_step = 0; ltc_in = 0;
        e_pc += 2;
        model_ltc();
        chk("R9 zero wins", pulse_count, 0);
        read_latch("R9 pre-zero copy", 0);
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R2 counting
        do_steps(1, 1, 13);
        check_counts("R2 counting");

        // R11 busy write refused, old selectors still act
        write_mode(1, 2'b10, 2'b10, 2'b00);
        ltc_event();
        check_counts("R11 old mode");
        read_latch("R11 pulse copy", 0);
        chk("R11 enc untouched", 32'(enc_valid), 0);
        write_mode(0, 2'b10, 2'b00, 2'b00);
        ltc_event();
        read_latch("R11 enc copy", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule